// File: doc/BRIEF.md
# PLL Output Channel Divider

This block sits between a PLL and the clock multiplexers it feeds. The parent PLL is modelled as a single-cycle clock-enable strobe plus a flag that says whether the PLL is producing a clock at all. The channel divides that strobe by a programmable integer. It then divides again by a fixed factor chosen per instance. The result is a thinned-out enable strobe for downstream logic.

Two separate control sources can gate the channel:

- a disable bit in the channel's own control word;
- a hold bit that software keeps in the register it shares with the parent PLL.

While either bit is set, or while the parent is not running, the channel emits nothing and its divide state is cleared.

The programmable divisor has two special rules:

- A zero field means the largest divisor, not a bypass.
- A new divisor is only picked up at an output strobe boundary, so a reprogramming never shortens or stretches the period in flight.

Top module: `pll_chan_div`

## Requirements
- R1: While `cfg_disable` is 1, `chan_tick` stays 0 and `chan_active` is 0.
- R2: While `cfg_hold` is 1, `chan_tick` stays 0 and `chan_active` is 0.
- R3: While `pll_running` is 0, `chan_tick` stays 0 and `chan_active` is 0.
- R4: `chan_active` is 1 exactly when `cfg_disable` is 0, `cfg_hold` is 0 and `pll_running` is 1. This also holds during reset.
- R5: With the channel active, `chan_tick` is asserted in the same cycle as the N-th `pll_tick` counted from the previous output strobe or from the restart. N = D × FIXED_DIV, where D is the latched `cfg_div` value (1..255 for the default 8-bit field).
- R6: A `cfg_div` value of 0 acts as a divisor of 255, the all-ones value of the field.
- R7: Instances with `FIXED_DIV` greater than 1 multiply the period by that factor. For example, FIXED_DIV = 3 with D = 3 fires once every 9 input strobes.
- R8: When the channel becomes active again after a stopped interval, counting starts from zero. The divisor used is the `cfg_div` value present at the last clock edge of the stopped interval.
- R9: A change of `cfg_div` while the channel is active takes effect only for the period that starts after the next `chan_tick`.
- R10: `chan_tick` is never asserted in a cycle where `pll_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_tick | input | 1 | Clock-enable strobe from the parent PLL |
| pll_running | input | 1 | Parent PLL is producing a clock |
| cfg_disable | input | 1 | Channel disable bit from the channel control word |
| cfg_hold | input | 1 | Channel hold bit from the shared PLL-level register |
| cfg_div | input | DIV_W | Programmable integer divisor; 0 selects the maximum |
| chan_tick | output | 1 | Divided clock-enable strobe |
| chan_active | output | 1 | Channel is enabled, not held, and its parent runs |

## Verification
The hardest situation to reach is a divisor change that lands in the middle of a period. It has to be shown that the old ratio still governs the strobe in flight and that the new one starts cleanly afterwards. The stimulus provokes this by running with one divisor, rewriting `cfg_div` two input strobes into a period, and then comparing every cycle against a behavioural counter model.

The same comparison runs on a second instance with a fixed post-divider of 3. This exposes how the cascaded counters interact at the boundary. The stimulus also uses sparse strobe patterns, so that the boundary does not always coincide with consecutive clock cycles.

// File: rtl/pll_chan_div.sv
module pll_chan_div #(
  parameter int DIV_W     = 8,
  parameter int FIXED_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_tick,
  input  logic             pll_running,
  input  logic             cfg_disable,
  input  logic             cfg_hold,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             chan_tick,
  output logic             chan_active
);

  localparam int FX_W = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = '1;

  logic [DIV_W-1:0] div_eff, div_lat, pcnt;
  logic             prog_wrap, fix_wrap;

  assign div_eff     = (cfg_div == '0) ? DIV_MAX : cfg_div;
  assign chan_active = !cfg_disable && !cfg_hold && pll_running;
  assign prog_wrap   = chan_active && pll_tick && (pcnt == div_lat - DIV_W'(1));
  assign chan_tick   = prog_wrap && fix_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt    <= '0;
      div_lat <= DIV_MAX;
    end else if (!chan_active) begin
      pcnt    <= '0;
      div_lat <= div_eff;
    end else if (prog_wrap) begin
      pcnt <= '0;
      if (fix_wrap) div_lat <= div_eff;
    end else if (pll_tick) begin
      pcnt <= pcnt + DIV_W'(1);
    end
  end

  generate
    if (FIXED_DIV > 1) begin : g_fixed
      logic [FX_W-1:0] fcnt;
      assign fix_wrap = (fcnt == FX_W'(FIXED_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !chan_active) fcnt <= '0;
        else if (prog_wrap)         fcnt <= fix_wrap ? '0 : fcnt + FX_W'(1);
      end
    end else begin : g_nofixed
      assign fix_wrap = 1'b1;
    end
  endgenerate

  int chk_gap, chk_ratio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_gap   <= 0;
      chk_ratio <= (2**DIV_W - 1) * FIXED_DIV;
    end else if (!chan_active || chan_tick) begin
      chk_gap   <= 0;
      chk_ratio <= ((cfg_div == '0) ? (2**DIV_W - 1) : int'(cfg_div)) * FIXED_DIV;
    end else if (pll_tick) begin
      chk_gap <= chk_gap + 1;
    end
  end

  assert_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_tick |-> (chk_gap + 1 == chk_ratio));
  assert_no_missed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_active && pll_tick && (chk_gap + 1 == chk_ratio)) |-> chan_tick);
  assert_quiet_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable |-> (!chan_tick && !chan_active));
  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |-> (!chan_tick && !chan_active));
  assert_quiet_parent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_running |-> (!chan_tick && !chan_active));
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_active) |-> (pcnt == '0));
  assert_needs_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_tick |-> !chan_tick);

endmodule

// File: tb/tb_pll_chan_div.sv
`timescale 1ns/1ps
module tb_pll_chan_div;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, tick, run, dis, hold;
  logic [7:0] div;
  logic       t0, a0, t1, a1;

  pll_chan_div #(.DIV_W(8), .FIXED_DIV(1)) dut (
    .clk(clk), .rst_n(rst_n), .pll_tick(tick), .pll_running(run),
    .cfg_disable(dis), .cfg_hold(hold), .cfg_div(div),
    .chan_tick(t0), .chan_active(a0));

  pll_chan_div #(.DIV_W(8), .FIXED_DIV(3)) dut_fx (
    .clk(clk), .rst_n(rst_n), .pll_tick(tick), .pll_running(run),
    .cfg_disable(dis), .cfg_hold(hold), .cfg_div(div),
    .chan_tick(t1), .chan_active(a1));

  int    cnt[2];
  int    ratio[2];
  int    fx[2] = '{1, 3};
  int    vectors = 0, miscompares = 0;
  string cur_req = "R4";

  function automatic int eff(input logic [7:0] d);
    return (d == 8'd0) ? 255 : int'(d);
  endfunction

  function automatic bit act();
    return !dis && !hold && run;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        cnt[k] = 0; ratio[k] = 255 * fx[k];
      end else if (!act()) begin
        cnt[k] = 0; ratio[k] = eff(div) * fx[k];
      end else if (tick) begin
        if (cnt[k] + 1 == ratio[k]) begin
          cnt[k] = 0; ratio[k] = eff(div) * fx[k];
        end else begin
          cnt[k] = cnt[k] + 1;
        end
      end
    end
  end

  task automatic chk(input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual %0b expected %0b", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("dut.chan_active", a0, act());
    chk("dut_fx.chan_active", a1, act());
    chk("dut.chan_tick", t0, rst_n && act() && tick && (cnt[0] + 1 == ratio[0]));
    chk("dut_fx.chan_tick", t1, rst_n && act() && tick && (cnt[1] + 1 == ratio[1]));
  end

  task automatic cyc(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick = (pat == 0) ? 1'b1 : (pat == 1) ? (i % 3 != 0) : 1'b0;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; dis = 1; hold = 0; run = 1; div = 8'd0; tick = 0;
    cur_req = "R4";
    repeat (4) @(posedge clk); #1;
    rst_n = 1;
    cyc(3, 0);
    // R5: basic ratio with dense and sparse input strobes
    cur_req = "R5"; div = 8'd4; cyc(1, 2); dis = 0;
    cyc(40, 0); cyc(45, 1);
    // R10: no input strobes while active
    cur_req = "R10"; cyc(20, 2);
    // R9: divisor rewritten mid period
    cur_req = "R9"; div = 8'd2; cyc(2, 0); div = 8'd6; cyc(40, 0); cyc(30, 1);
    // R1 then R8: disable mid-count, re-enable restarts
    cur_req = "R1"; cyc(3, 0); dis = 1; cyc(10, 0); div = 8'd5;
    cur_req = "R8"; dis = 0; cyc(40, 0);
    // R2: hold from the shared PLL register
    cur_req = "R2"; cyc(2, 0); hold = 1; cyc(10, 0); hold = 0; cyc(20, 1);
    // R3: parent stopped
    cur_req = "R3"; cyc(3, 0); run = 0; cyc(10, 0); run = 1; cyc(20, 0);
    // R4: gating combinations
    cur_req = "R4";
    dis = 1; hold = 1; cyc(3, 0); dis = 0; cyc(3, 0); hold = 0; run = 0; cyc(3, 0);
    dis = 1; cyc(3, 0); dis = 0; run = 1; cyc(5, 0);
    // R6: zero field means 255
    cur_req = "R6"; div = 8'd0; dis = 1; cyc(1, 0); dis = 0; cyc(1600, 0);
    // R7: fixed post-divider with a small divisor
    cur_req = "R7"; div = 8'd3; dis = 1; cyc(1, 0); dis = 0; cyc(60, 1); cyc(30, 0);
    // R5: divisor one
    cur_req = "R5"; div = 8'd1; dis = 1; cyc(1, 0); dis = 0; cyc(12, 0); cyc(12, 1);
    summary();
    $finish;
  end

endmodule